// File: doc/BRIEF.md
# Low-Power Clock Enable Controller

This block turns the low-power field of a small processor's status word into four clock enables: one for the CPU main clock, one for the low-frequency crystal clock, one for the fast oscillator and one for the sub-system clock. The status word's bits 7:4 each switch one clock off. A separate byte-wide override mask lets a pending DMA request turn individual gated clocks back on without waking the CPU. A registered grant tells the DMA engine when every clock the transfer needs is running.

The block also models what the processor does with the low-power field across an interrupt:

- On interrupt accept, the field is saved to a stacked copy and cleared, so the CPU wakes to run the handler.
- The handler can clear bits in the stacked copy.
- Interrupt return restores the stacked copy. If the handler cleared bits, the processor leaves low-power mode.

A decoded mode code reports which of the five standard low-power modes is active.

Top module: `lpc_ctrl`

## Requirements
- R1: After reset all four enables are 1, `dma_grant` is 0, `lp_mode` is 5 (active), and the low-power, override and stacked state is all zero.
- R2: A status write (`sr_wr`) loads `sr_wdata[7:4]` into the low-power field and ignores `sr_wdata[3:0]`. The bit mapping is: bit 4 switches off `en_cpu`, bit 5 `en_lfxt`, bit 6 `en_fast`, bit 7 `en_sub`. The enables change at the same clock edge that takes the write.
- R3: `lp_mode` decodes the field `sr[7:4]` as follows: 0x1 gives 0, 0x5 gives 1, 0x9 gives 2, 0xD gives 3, 0xF gives 4. Any field with bit 4 clear gives 5, and every other field gives 6.
- R4: An override write (`ovr_wr`) keeps only `ovr_wdata[3:0]`. Bit 0 maps to the CPU clock, bit 1 to lfxt, bit 2 to fast and bit 3 to sub. Each enable equals NOT(off bit) OR (`dma_req` AND override bit). All 16 override combinations are legal, and bits 7:4 have no effect.
- R5: The enables are registered. They respond to a change of `dma_req` at the next clock edge, both when the request rises and when it falls.
- R6: While `clk_sel_fast` is 1 and the CPU clock is enabled, `en_fast` is forced to 1.
- R7: `dma_grant` rises one edge after every clock selected in `dma_need` is enabled while `dma_req` is high. `dma_need` uses the same bit order as the override mask. `dma_grant` is 0 in any cycle in which `dma_req` is 0.
- R8: `irq_accept` copies the low-power field into the stacked copy and clears the field at the same edge, so all clocks run.
- R9: `stk_clr` clears the stacked bits selected by `stk_clr_mask[7:4]`. `irq_return` loads the stacked copy back into the low-power field.
- R10: When several strobes arrive in the same cycle, the priority is `irq_accept` first, then `irq_return`, then `sr_wr`.
- R11: A status write with bits 7:4 zero leaves any low-power mode and enables every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_wr | input | 1 | Status word write strobe |
| sr_wdata | input | 8 | Status word value; bits 7:4 are the low-power field |
| ovr_wr | input | 1 | Override mask write strobe |
| ovr_wdata | input | 8 | Override mask; bits 3:0 are used |
| irq_accept | input | 1 | Interrupt accepted: save and clear the low-power field |
| stk_clr | input | 1 | Clear bits of the stacked low-power field |
| stk_clr_mask | input | 8 | Bits 7:4 select the stacked bits to clear |
| irq_return | input | 1 | Interrupt return: restore the stacked field |
| clk_sel_fast | input | 1 | Main clock is sourced from the fast oscillator |
| dma_req | input | 1 | DMA transfer request |
| dma_need | input | 4 | Clocks the transfer needs (cpu, lfxt, fast, sub) |
| en_cpu | output | 1 | CPU main clock enable |
| en_lfxt | output | 1 | Low-frequency crystal clock enable |
| en_fast | output | 1 | Fast oscillator enable |
| en_sub | output | 1 | Sub-system clock enable |
| dma_grant | output | 1 | All needed clocks are running |
| lp_mode | output | 3 | Decoded low-power mode code |

## Verification
The hardest condition to reach is a handler that clears only some of the stacked bits before it returns. A partial clear must bring back a different, still valid low-power mode rather than full activity. The bench gets there in three steps:

1. It enters mode 3 with a status write.
2. It raises `irq_accept` and pulses `stk_clr` with only bit 7 set.
3. It raises `irq_return` and expects mode 1.

The bench also reaches the grant window by holding `dma_req` through all 16 override masks with every clock off.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    localparam int NCLK     = 4;
    localparam int CK_CPU   = 0;
    localparam int CK_LFXT  = 1;
    localparam int CK_FAST  = 2;
    localparam int CK_SUB   = 3;
    localparam int MODE_W   = 3;

    localparam logic [MODE_W-1:0] MODE_ACTIVE = 3'd5;
    localparam logic [MODE_W-1:0] MODE_OTHER  = 3'd6;

    typedef struct packed {
        logic [NCLK-1:0] lp;
        logic [NCLK-1:0] ovr;
        logic [NCLK-1:0] stk;
        logic [NCLK-1:0] en;
        logic            grant;
    } lpc_state_t;
endpackage

// File: rtl/lpc_en_calc.sv
module lpc_en_calc
    import lpc_pkg::*;
#(
    parameter int N = NCLK
) (
    input  logic [N-1:0] off_bits,
    input  logic [N-1:0] ovr_bits,
    input  logic         req,
    input  logic         sel_fast,
    output logic [N-1:0] en
);
    logic [N-1:0] raw;

    for (genvar i = 0; i < N; i++) begin : g_clk
        assign raw[i] = ~off_bits[i] | (req & ovr_bits[i]);
    end

    always_comb begin
        en = raw;
        if (sel_fast && raw[CK_CPU]) begin
            en[CK_FAST] = 1'b1;
        end
    end
endmodule

// File: rtl/lpc_mode_dec.sv
module lpc_mode_dec
    import lpc_pkg::*;
#(
    parameter int N = NCLK
) (
    input  logic [N-1:0]      lp,
    output logic [MODE_W-1:0] mode
);
    always_comb begin
        if (!lp[CK_CPU]) begin
            mode = MODE_ACTIVE;
        end else begin
            unique case (lp)
                4'b0001: mode = 3'd0;
                4'b0101: mode = 3'd1;
                4'b1001: mode = 3'd2;
                4'b1101: mode = 3'd3;
                4'b1111: mode = 3'd4;
                default: mode = MODE_OTHER;
            endcase
        end
    end

    always_comb begin
        AST_MODE_RANGE: assert (mode <= MODE_OTHER); // R3
    end
endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
    import lpc_pkg::*;
#(
    parameter int SR_W   = 8,
    parameter int LP_LSB = 4,
    parameter int OVR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_wr,
    input  logic [SR_W-1:0]   sr_wdata,
    input  logic              ovr_wr,
    input  logic [OVR_W-1:0]  ovr_wdata,
    input  logic              irq_accept,
    input  logic              stk_clr,
    input  logic [SR_W-1:0]   stk_clr_mask,
    input  logic              irq_return,
    input  logic              clk_sel_fast,
    input  logic              dma_req,
    input  logic [NCLK-1:0]   dma_need,
    output logic              en_cpu,
    output logic              en_lfxt,
    output logic              en_fast,
    output logic              en_sub,
    output logic              dma_grant,
    output logic [MODE_W-1:0] lp_mode
);
    localparam int LP_MSB = LP_LSB + NCLK - 1;

    lpc_state_t      s_q, s_d;
    logic [NCLK-1:0] lp_d, ovr_d, stk_d, en_d;

    logic unused_bits;
    assign unused_bits = ^{sr_wdata[LP_LSB-1:0], stk_clr_mask[LP_LSB-1:0],
                           ovr_wdata[OVR_W-1:NCLK]};

    // next low-power field, override mask and stacked copy
    always_comb begin
        lp_d  = s_q.lp;
        ovr_d = s_q.ovr;
        stk_d = s_q.stk;
        if (ovr_wr) begin
            ovr_d = ovr_wdata[NCLK-1:0];
        end
        if (irq_accept) begin
            stk_d = s_q.lp;
        end else if (stk_clr) begin
            stk_d = s_q.stk & ~stk_clr_mask[LP_MSB:LP_LSB];
        end
        if (irq_accept) begin
            lp_d = '0;
        end else if (irq_return) begin
            lp_d = s_q.stk;
        end else if (sr_wr) begin
            lp_d = sr_wdata[LP_MSB:LP_LSB];
        end
    end

    lpc_en_calc #(.N(NCLK)) u_en (
        .off_bits (lp_d),
        .ovr_bits (ovr_d),
        .req      (dma_req),
        .sel_fast (clk_sel_fast),
        .en       (en_d)
    );

    always_comb begin
        s_d       = s_q;
        s_d.lp    = lp_d;
        s_d.ovr   = ovr_d;
        s_d.stk   = stk_d;
        s_d.en    = en_d;
        s_d.grant = dma_req && ((dma_need & ~s_q.en) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lp    <= '0;
            s_q.ovr   <= '0;
            s_q.stk   <= '0;
            s_q.en    <= '1;
            s_q.grant <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    lpc_mode_dec #(.N(NCLK)) u_mode (
        .lp   (s_q.lp),
        .mode (lp_mode)
    );

    assign en_cpu    = s_q.en[CK_CPU];
    assign en_lfxt   = s_q.en[CK_LFXT];
    assign en_fast   = s_q.en[CK_FAST];
    assign en_sub    = s_q.en[CK_SUB];
    assign dma_grant = s_q.grant & dma_req;

    for (genvar i = 0; i < NCLK; i++) begin : g_ast
        if (i != CK_FAST) begin : g_plain
            AST_GATED_HAS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                !s_q.en[i] |-> s_q.lp[i]); // R2
        end
    end

    AST_FAST_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en[CK_CPU] && $past(clk_sel_fast)) |-> s_q.en[CK_FAST]); // R6

    AST_GRANT_CLKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.grant) |-> ($past(dma_req) && (($past(dma_need) & ~$past(s_q.en)) == '0))); // R7

    AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> (s_q.lp == '0 && s_q.stk == $past(s_q.lp))); // R8
endmodule

// File: tb/lpc_ctrl_tb.sv
module lpc_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sr_wr = 0, ovr_wr = 0, irq_accept = 0, stk_clr = 0, irq_return = 0;
    logic       clk_sel_fast = 0, dma_req = 0;
    logic [7:0] sr_wdata = 0, ovr_wdata = 0, stk_clr_mask = 0;
    logic [3:0] dma_need = 4'hF;
    logic       en_cpu, en_lfxt, en_fast, en_sub, dma_grant;
    logic [2:0] lp_mode;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    lpc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata), .irq_accept(irq_accept),
        .stk_clr(stk_clr), .stk_clr_mask(stk_clr_mask), .irq_return(irq_return),
        .clk_sel_fast(clk_sel_fast), .dma_req(dma_req), .dma_need(dma_need),
        .en_cpu(en_cpu), .en_lfxt(en_lfxt), .en_fast(en_fast), .en_sub(en_sub),
        .dma_grant(dma_grant), .lp_mode(lp_mode)
    );

    function automatic logic [3:0] en_now();
        return {en_sub, en_fast, en_lfxt, en_cpu};
    endfunction

    // expected enables from the requirement formula, off = sr[7:4]
    function automatic logic [3:0] exp_en(logic [3:0] off, logic [3:0] ovr, logic req, logic sel);
        logic [3:0] e;
        for (int i = 0; i < 4; i++) e[i] = !off[i] || (req && ovr[i]);
        if (sel && e[0]) e[2] = 1'b1;
        return e;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_sr(logic [7:0] v);
        sr_wr = 1; sr_wdata = v; step(); sr_wr = 0;
    endtask

    task automatic wr_ovr(logic [7:0] v);
        ovr_wr = 1; ovr_wdata = v; step(); ovr_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1 enables", {4'h0, en_now()}, 8'h0F);
        chk("R1 grant", {7'h0, dma_grant}, 8'h00);
        chk("R1 mode", {5'h0, lp_mode}, 8'd5);
    endtask

    task automatic t_sr_bits();
        for (int b = 0; b < 4; b++) begin
            wr_sr(8'h0F | (8'h10 << b));
            chk("R2 single off bit", {4'h0, en_now()}, {4'h0, exp_en(4'b1 << b, 4'h0, 0, 0)});
        end
        wr_sr(8'h00);
    endtask

    task automatic t_modes();
        wr_sr(8'h10); chk("R3 mode0", {5'h0, lp_mode}, 8'd0);
        wr_sr(8'h50); chk("R3 mode1", {5'h0, lp_mode}, 8'd1);
        wr_sr(8'h90); chk("R3 mode2", {5'h0, lp_mode}, 8'd2);
        wr_sr(8'hD0); chk("R3 mode3", {5'h0, lp_mode}, 8'd3);
        wr_sr(8'hF0); chk("R3 mode4", {5'h0, lp_mode}, 8'd4);
        wr_sr(8'hE0); chk("R3 cpu on", {5'h0, lp_mode}, 8'd5);
        wr_sr(8'h30); chk("R3 other", {5'h0, lp_mode}, 8'd6);
        chk("R2 0x30 enables", {4'h0, en_now()}, 8'h0C);
    endtask

    task automatic t_exit();
        wr_sr(8'hF0);
        wr_sr(8'h0F);
        chk("R11 exit enables", {4'h0, en_now()}, 8'h0F);
        chk("R11 exit mode", {5'h0, lp_mode}, 8'd5);
    endtask

    task automatic t_override();
        wr_sr(8'hF0);
        dma_req = 1;
        for (int c = 0; c < 16; c++) begin
            wr_ovr({4'hA, 4'(c)});
            chk("R4 override combo", {4'h0, en_now()}, {4'h0, 4'(c)});
        end
        dma_req = 0; step();
        chk("R4 no req gates all", {4'h0, en_now()}, 8'h00);
        wr_ovr(8'hF0); dma_req = 1; step();
        chk("R4 upper override bits ignored", {4'h0, en_now()}, 8'h00);
        dma_req = 0; step();
    endtask

    task automatic t_dma_timing();
        wr_sr(8'hF0); wr_ovr(8'h0F); dma_need = 4'hF;
        dma_req = 1; #1;
        chk("R5 enables wait for edge", {4'h0, en_now()}, 8'h00);
        step();
        chk("R5 enables after rise", {4'h0, en_now()}, 8'h0F);
        chk("R7 no grant yet", {7'h0, dma_grant}, 8'h00);
        step();
        chk("R7 grant", {7'h0, dma_grant}, 8'h01);
        dma_req = 0; #1;
        chk("R7 grant drops with req", {7'h0, dma_grant}, 8'h00);
        chk("R5 enables hold until edge", {4'h0, en_now()}, 8'h0F);
        step();
        chk("R5 enables after fall", {4'h0, en_now()}, 8'h00);
    endtask

    task automatic t_grant_partial();
        wr_sr(8'hF0); wr_ovr(8'h01);
        dma_need = 4'b0011; dma_req = 1;
        for (int k = 0; k < 4; k++) step();
        chk("R7 missing clock blocks grant", {7'h0, dma_grant}, 8'h00);
        dma_need = 4'b0001; step();
        chk("R7 grant with covered need", {7'h0, dma_grant}, 8'h01);
        dma_req = 0; step();
        dma_need = 4'b0000; dma_req = 1; step();
        chk("R7 empty need grants next edge", {7'h0, dma_grant}, 8'h01);
        dma_req = 0; dma_need = 4'hF; wr_ovr(8'h00); step();
    endtask

    task automatic t_fast_force();
        wr_sr(8'h40); clk_sel_fast = 1; step();
        chk("R6 fast forced", {4'h0, en_now()}, {4'h0, exp_en(4'b0100, 4'h0, 0, 1)});
        clk_sel_fast = 0; step();
        chk("R6 fast released", {4'h0, en_now()}, 8'h0B);
        wr_sr(8'h50); clk_sel_fast = 1; step();
        chk("R6 cpu off no force", {4'h0, en_now()}, 8'h0A);
        clk_sel_fast = 0; wr_sr(8'h00);
    endtask

    task automatic t_irq();
        wr_sr(8'hD0);
        irq_accept = 1; step(); irq_accept = 0;
        chk("R8 accept wakes", {4'h0, en_now()}, 8'h0F);
        chk("R8 accept mode", {5'h0, lp_mode}, 8'd5);
        irq_return = 1; step(); irq_return = 0;
        chk("R9 return restores", {5'h0, lp_mode}, 8'd3);
        irq_accept = 1; step(); irq_accept = 0;
        stk_clr = 1; stk_clr_mask = 8'h8F; step(); stk_clr = 0;
        irq_return = 1; step(); irq_return = 0;
        chk("R9 partial clear mode1", {5'h0, lp_mode}, 8'd1);
        irq_accept = 1; step(); irq_accept = 0;
        stk_clr = 1; stk_clr_mask = 8'hF0; step(); stk_clr = 0;
        irq_return = 1; step(); irq_return = 0;
        chk("R9 full clear exits", {4'h0, en_now()}, 8'h0F);
    endtask

    task automatic t_priority();
        wr_sr(8'h10);
        irq_accept = 1; sr_wr = 1; sr_wdata = 8'hF0; step();
        irq_accept = 0; sr_wr = 0;
        chk("R10 accept beats write", {5'h0, lp_mode}, 8'd5);
        irq_return = 1; sr_wr = 1; sr_wdata = 8'hF0; step();
        irq_return = 0; sr_wr = 0;
        chk("R10 return beats write", {5'h0, lp_mode}, 8'd0);
        wr_sr(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sr_bits();
        t_modes();
        t_exit();
        t_override();
        t_dma_timing();
        t_grant_partial();
        t_fast_force();
        t_irq();
        t_priority();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule